// File: doc/BRIEF.md
# Addressable Serial Attenuation Control Register

This block is the digital control front end of a seven-bit step attenuator. A host sends a 16-bit frame over three wires: serial data, serial clock and latch strobe. The block samples all three in its own system clock domain. It shifts in one bit on each serial clock rise while the strobe is low. When the strobe rises, the frame is committed to the attenuation state register. This happens only if the frame's address field matches the three static address pins of this device, so several attenuators can share one serial bus.

The attenuation code is a binary count of quarter-decibel steps. Bit 0 is the 0.25 dB step and bit 6 is the 16 dB step, so 7'h7F means 31.75 dB. At reset the block holds maximum attenuation. The top bit of the attenuation byte is reserved and must be sent as zero. If a frame addressed to this device carries it set, a sticky error flag is raised and the lower seven bits are still applied.

Top module: `satt_ctrl`

## Requirements
- R1: After a synchronous reset, `atten_code` is 7'h7F and `rsv_err` is 0.
- R2: A frame is 16 bits sent least significant bit first. After 16 shifts, frame bits [7:0] are the attenuation byte (sent first) and bits [15:8] are the address byte (sent last). On a matching commit, `atten_code` takes frame bits [6:0].
- R3: Only frame bits [10:8] are compared with `dev_addr[2:0]` (bit 8 against `dev_addr[0]`). Frame bits [15:11] have no effect on whether the frame matches.
- R4: A commit whose frame bits [10:8] differ from `dev_addr` leaves `atten_code` and `rsv_err` unchanged.
- R5: `atten_code` does not change while bits are shifted in with the strobe low.
- R6: A matching commit with frame bit 7 set sets `rsv_err`, which stays set until reset. A mismatching frame with bit 7 set does not set it.
- R7: Serial clock rises beyond 16 keep shifting. The last 16 bits received before the strobe rises are the ones committed.
- R8: Each input passes a two-flop synchroniser. A strobe rise first seen at system clock edge n updates the outputs at edge n+2.
- R9: A serial clock rise whose synchronised copy coincides with a high synchronised strobe does not shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_din | input | 1 | Serial data |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_strobe | input | 1 | Latch strobe; low while shifting, rising edge commits |
| dev_addr | input | 3 | Static device address pins |
| atten_code | output | 7 | Attenuation state, 0.25 dB per LSB |
| rsv_err | output | 1 | Sticky flag: reserved bit 7 seen in a matching frame |

## Verification
Two events can land in the same system cycle: a serial clock rise and a strobe rise. The bench provokes this by driving both inputs high on the same clock, with a seventeenth data bit on the line. The shift must be suppressed and the commit must use the previous 16 bits. The test frame is chosen so that a shifted frame would miss the address and would leave a different code. A behavioural model in the bench, fed the same inputs, is compared on every clock. It also judges the exact commit cycle.

// File: rtl/satt_pkg.sv
package satt_pkg;
  localparam int FRAME_BITS = 16;
  localparam int BYTE_BITS  = 8;
  localparam int CODE_BITS  = 7;
  localparam int ADDR_BITS  = 3;
  localparam int SYNC_DEPTH = 2;
  typedef enum logic [1:0] {IN_DIN = 2'd0, IN_SCLK = 2'd1, IN_STROBE = 2'd2} sync_lane_e;
endpackage

// File: rtl/satt_sync.sv
module satt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/satt_shifter.sv
module satt_shifter #(
  parameter int FRAME_W = 16,
  parameter int KEEP_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din_s,
  input  logic              sclk_s,
  input  logic              strobe_s,
  output logic [KEEP_W-1:0] frame_lo,
  output logic              commit
);
  logic [FRAME_W-1:0] shreg;
  logic               sclk_d, strobe_d;
  logic               shift_en;

  assign shift_en = sclk_s & ~sclk_d & ~strobe_s;
  assign commit   = strobe_s & ~strobe_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      sclk_d   <= 1'b0;
      strobe_d <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      strobe_d <= strobe_s;
      if (shift_en) shreg <= {din_s, shreg[FRAME_W-1:1]};
    end
  end

  assign frame_lo = shreg[KEEP_W-1:0];
endmodule

// File: rtl/satt_state.sv
module satt_state #(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 7,
  parameter int ADDR_W = 3,
  localparam int KEEP_W = BYTE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [KEEP_W-1:0] frame_lo,
  input  logic              commit,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              addr_hit,
  output logic [CODE_W-1:0] code_q,
  output logic              err_q
);
  assign addr_hit = (frame_lo[BYTE_W +: ADDR_W] == dev_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '1;
      err_q  <= 1'b0;
    end else if (commit && addr_hit) begin
      code_q <= frame_lo[CODE_W-1:0];
      if (frame_lo[BYTE_W-1]) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/satt_ctrl.sv
module satt_ctrl
  import satt_pkg::*;
#(
  parameter int FRAME_W = FRAME_BITS,
  parameter int BYTE_W  = BYTE_BITS,
  parameter int CODE_W  = CODE_BITS,
  parameter int ADDR_W  = ADDR_BITS,
  parameter int STAGES  = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_din,
  input  logic              ser_clk,
  input  logic              ser_strobe,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic [CODE_W-1:0] atten_code,
  output logic              rsv_err
);
  localparam int KEEP_W = BYTE_W + ADDR_W;

  logic [2:0]        raw_in, sync_out;
  logic [KEEP_W-1:0] frame_lo;
  logic              commit, addr_hit;

  assign raw_in[IN_DIN]    = ser_din;
  assign raw_in[IN_SCLK]   = ser_clk;
  assign raw_in[IN_STROBE] = ser_strobe;

  satt_sync #(.W(3), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  satt_shifter #(.FRAME_W(FRAME_W), .KEEP_W(KEEP_W)) u_shift (
    .clk(clk), .rst(rst),
    .din_s(sync_out[IN_DIN]), .sclk_s(sync_out[IN_SCLK]), .strobe_s(sync_out[IN_STROBE]),
    .frame_lo(frame_lo), .commit(commit)
  );

  satt_state #(.BYTE_W(BYTE_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_state (
    .clk(clk), .rst(rst), .frame_lo(frame_lo), .commit(commit), .dev_addr(dev_addr),
    .addr_hit(addr_hit), .code_q(atten_code), .err_q(rsv_err)
  );
endmodule

// File: rtl/satt_ctrl_chk.sv
module satt_ctrl_chk #(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 7,
  parameter int ADDR_W = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     commit,
  input logic                     addr_hit,
  input logic [BYTE_W+ADDR_W-1:0] frame_lo,
  input logic [CODE_W-1:0]        atten_code,
  input logic                     rsv_err
);
  AST_RESET_MAX: assert property (@(posedge clk) rst |=> (atten_code == '1) && !rsv_err); // R1
  AST_LOAD_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    commit && addr_hit |=> atten_code == $past(frame_lo[CODE_W-1:0])); // R2
  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    commit && !addr_hit |=> $stable(atten_code) && $stable(rsv_err)); // R4
  AST_NO_CHANGE_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(atten_code)); // R5
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (rst)
    commit && addr_hit && frame_lo[BYTE_W-1] |=> rsv_err); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    rsv_err |=> rsv_err); // R6
endmodule

bind satt_ctrl satt_ctrl_chk #(.BYTE_W(BYTE_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .commit(commit), .addr_hit(addr_hit), .frame_lo(frame_lo),
  .atten_code(atten_code), .rsv_err(rsv_err)
);

// File: tb/sim_satt_ctrl.sv
`timescale 1ns/1ps
module sim_satt_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0, sclk = 1'b0, strobe = 1'b0;
  logic [2:0] pins = 3'b011;
  logic [6:0] code;
  logic       err;
  int         n_vec = 0, n_bad = 0;
  string      phase = "R1";
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  satt_ctrl u0 (
    .clk(clk), .rst(rst), .ser_din(din), .ser_clk(sclk), .ser_strobe(strobe),
    .dev_addr(pins), .atten_code(code), .rsv_err(err)
  );

  // behavioural reference: input delay queues and a 16-entry bit queue
  bit       q_din[$], q_sclk[$], q_stb[$];
  bit       bits[$];
  bit       p_sclk, p_stb;
  int       m_code = 127;
  bit       m_err = 0;

  always @(posedge clk) begin
    if (rst) begin
      q_din = {0, 0}; q_sclk = {0, 0}; q_stb = {0, 0};
      bits.delete(); for (int i = 0; i < 16; i++) bits.push_back(0);
      p_sclk = 0; p_stb = 0; m_code = 127; m_err = 0;
    end else begin
      bit d2, c2, s2;
      d2 = q_din[0]; c2 = q_sclk[0]; s2 = q_stb[0];
      if (s2 && !p_stb) begin
        int a, w;
        a = 0; w = 0;
        for (int i = 0; i < 3; i++) a += int'(bits[8+i]) << i;
        for (int i = 0; i < 8; i++) w += int'(bits[i]) << i;
        if (a == int'(pins)) begin
          m_code = w % 128;
          if (w >= 128) m_err = 1;
        end
      end
      if (c2 && !p_sclk && !s2) begin
        void'(bits.pop_front());
        bits.push_back(d2);
      end
      p_sclk = c2; p_stb = s2;
      void'(q_din.pop_front());  q_din.push_back(din);
      void'(q_sclk.pop_front()); q_sclk.push_back(sclk);
      void'(q_stb.pop_front());  q_stb.push_back(strobe);
    end
  end

  always @(negedge clk) if (!rst && !done) begin
    n_vec++;
    if (int'(code) != m_code || err != m_err) begin
      n_bad++;
      $display("FAIL %s/R8 per-cycle: code=%h err=%b expected code=%h err=%b",
               phase, code, err, m_code[6:0], m_err);
    end
  end

  task automatic check(string req, logic [6:0] ec, logic ee);
    n_vec++;
    if (code !== ec || err !== ee) begin
      n_bad++;
      $display("FAIL %s: code=%h err=%b expected code=%h err=%b", req, code, err, ec, ee);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    din = b; sclk = 1'b0; tick(3);
    sclk = 1'b1; tick(3);
    sclk = 1'b0;
  endtask

  task automatic send_frame(logic [7:0] addr, logic [7:0] data);
    logic [15:0] f;
    f = {addr, data};
    for (int i = 0; i < 16; i++) send_bit(f[i]);
  endtask

  task automatic pulse_strobe();
    tick(2); strobe = 1'b1; tick(4); strobe = 1'b0; tick(4);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    tick(4); rst = 1'b0; tick(2);
    check("R1 reset state", 7'h7F, 1'b0);

    phase = "R2";
    send_frame(8'hF3, 8'h49); pulse_strobe();
    check("R2/R3 match with upper address junk", 7'h49, 1'b0);

    phase = "R4";
    send_frame(8'h05, 8'h10); pulse_strobe();
    check("R4 mismatch holds", 7'h49, 1'b0);
    send_frame(8'h1D, 8'h90); pulse_strobe();
    check("R6 mismatch with bit7 no flag", 7'h49, 1'b0);

    phase = "R5";
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    check("R5 half frame no change", 7'h49, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    tick(4);
    check("R5 full frame no change before strobe", 7'h49, 1'b0);
    pulse_strobe();
    check("R3 all-ones address mismatch on pins 011", 7'h49, 1'b0);

    phase = "R7";
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_frame(8'h03, 8'h2A); pulse_strobe();
    check("R7 extra leading pulses", 7'h2A, 1'b0);

    phase = "R9";
    send_frame(8'h03, 8'h33);
    tick(2); din = 1'b1; sclk = 1'b1; strobe = 1'b1; tick(4);
    sclk = 1'b0; strobe = 1'b0; tick(4);
    check("R9 simultaneous clock and strobe, no shift", 7'h33, 1'b0);

    phase = "R8";
    send_frame(8'h03, 8'h15);
    tick(2); strobe = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R8 two edges after strobe still old", 7'h33, 1'b0);
    @(posedge clk); #1;
    check("R8 third edge commits", 7'h15, 1'b0);
    tick(4); strobe = 1'b0; tick(4);

    phase = "R6";
    send_frame(8'h03, 8'h85); pulse_strobe();
    check("R6 bit7 set loads low bits and flags", 7'h05, 1'b1);
    send_frame(8'h03, 8'h00); pulse_strobe();
    check("R6 flag sticky", 7'h00, 1'b1);

    phase = "R3";
    pins = 3'b110;
    send_frame(8'hAE, 8'h7E); pulse_strobe();
    check("R3 new pin address match", 7'h7E, 1'b1);

    phase = "R1";
    @(negedge clk); rst = 1'b1; tick(2); rst = 1'b0; tick(1);
    check("R1 reset clears flag and sets max", 7'h7F, 1'b0);
    tick(3);
    finish_up();
  end
endmodule